// File: doc/BRIEF.md
# Flash Busy-State Access Guard

This block sits on the path between a CPU bus and a flash array. It decides how each CPU access is handled while the array is busy with a program or erase. A three-state mode machine records whether the array is idle, busy with a single-word program or an erase, or busy with a block program. Each access is judged against the recorded mode, the current WAIT status bit and the write-enable control bit. Reads and fetches then return either real array data or a fixed self-jump opcode (default 16'h3FFF). Writes are either forwarded to the array or dropped. Illegal accesses raise a sticky violation flag and, in the block cases, a sticky lock flag.

Mode states and transitions are named as follows. MODE_IDLE leaves on start_single (busy high, block low) or start_block (busy high, block high). MODE_SINGLE returns on single_done (busy low) and moves on to_block (block rises). MODE_BLOCK returns on block_done (busy low) and moves on to_single (block falls). Each state holds on stay. Both flags are cleared only by software, through a flag write port.

Top module: `flash_busy_guard`

## Requirements
- R1: A synchronous active-high reset clears viol_flag, lock_flag, cpu_rdata, array_we and array_wdata.
- R2: busy_in and blk_mode_in are captured into the mode register at every clock edge (busy low gives idle; busy high gives single or block depending on blk_mode_in). An access is judged against the mode captured at the previous edge. Its results are registered one clock after the access is presented. acc_kind codes: 2'b00 read, 2'b01 write, 2'b10 instruction fetch, 2'b11 no access.
- R3: In idle mode a read or fetch returns array_rdata on cpu_rdata. A write with wr_en_in=1 pulses array_we and presents cpu_wdata on array_wdata.
- R4: In idle mode, and in block mode with WAIT=1, a write with wr_en_in=0 sets viol_flag and does not pulse array_we.
- R5: In single mode a read or fetch returns the substitute opcode and does not set viol_flag.
- R6: In single mode a write is dropped (no array_we) and sets viol_flag.
- R7: In block mode with wait_in=0 any access sets viol_flag and lock_flag and drops writes. A read or fetch returns the substitute opcode. lock_flag rises only after an access made in block mode.
- R8: In block mode with wait_in=1 a read returns the substitute opcode without a violation. A write with wr_en_in=1 is forwarded to the array.
- R9: In block mode with wait_in=1 an instruction fetch sets viol_flag and lock_flag and returns the substitute opcode.
- R10: The flags are sticky. A flag_wr cycle with 0 in a flag's bit (bit 0 viol, bit 1 lock) clears that flag, and 1 leaves it unchanged. A new violation in the same cycle wins over the clear.
- R11: cpu_rdata holds its value across cycles with no read or fetch. array_we is high only in the cycle after a forwarded write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | CPU access present this cycle |
| acc_kind | input | 2 | Access type code |
| cpu_wdata | input | DATA_W | CPU write data |
| busy_in | input | 1 | Array program/erase in progress |
| blk_mode_in | input | 1 | Busy operation is a block program |
| wait_in | input | 1 | Block-program WAIT status |
| wr_en_in | input | 1 | Write-enable control bit |
| flag_wr | input | 1 | Software write strobe for the flags |
| flag_wdata | input | 2 | Flag write data (bit 0 viol, bit 1 lock) |
| array_rdata | input | DATA_W | Data read from the array |
| cpu_rdata | output | DATA_W | Registered data returned to the CPU |
| array_we | output | 1 | Registered write strobe to the array |
| array_wdata | output | DATA_W | Registered write data to the array |
| viol_flag | output | 1 | Sticky access-violation flag |
| lock_flag | output | 1 | Sticky lock flag |

## Verification
The mode register takes effect one edge after busy changes, and every access result appears at the edge after the access. The bench therefore first lets a mode settle for one clock and then clears the flags for one clock. It then drives the access on a falling edge and samples all outputs on the next falling edge, between the two rising edges that bound the result. The sweep covers every mode, WAIT, write-enable and access-kind combination, with expected values derived from a table of rules in the bench. Separate sequences probe the same-cycle mode latency, flag stickiness, per-bit clearing and set-over-clear priority.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_BLOCK  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    localparam int FLAG_VIOL = 0;
    localparam int FLAG_LOCK = 1;
    localparam int NUM_FLAGS = 2;

    typedef struct packed {
        logic rd_update;
        logic use_sub;
        logic wr_pass;
        logic set_viol;
        logic set_lock;
    } verdict_t;

endpackage

// File: rtl/fbg_mode_fsm.sv
module fbg_mode_fsm
    import fbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  blk,
    output mode_e mode_q
);

    mode_e mode_d;

    // Transition selection, one branch per named transition.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_IDLE: begin
                if (busy && !blk)     mode_d = MODE_SINGLE; // start_single
                else if (busy && blk) mode_d = MODE_BLOCK;  // start_block
                else                  mode_d = MODE_IDLE;   // stay
            end
            MODE_SINGLE: begin
                if (!busy)    mode_d = MODE_IDLE;   // single_done
                else if (blk) mode_d = MODE_BLOCK;  // to_block
                else          mode_d = MODE_SINGLE; // stay
            end
            MODE_BLOCK: begin
                if (!busy)     mode_d = MODE_IDLE;   // block_done
                else if (!blk) mode_d = MODE_SINGLE; // to_single
                else           mode_d = MODE_BLOCK;  // stay
            end
            default: mode_d = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_IDLE;
        else     mode_q <= mode_d;
    end

endmodule

// File: rtl/fbg_policy.sv
module fbg_policy
    import fbg_pkg::*;
(
    input  mode_e      mode,
    input  logic       acc_valid,
    input  logic [1:0] acc_kind,
    input  logic       wait_bit,
    input  logic       wr_en,
    output verdict_t   verdict
);

    acc_e kind;
    logic is_rd;
    logic is_wr;
    logic is_fe;

    always_comb begin
        kind  = acc_valid ? acc_e'(acc_kind) : ACC_NONE;
        is_rd = (kind == ACC_READ);
        is_wr = (kind == ACC_WRITE);
        is_fe = (kind == ACC_FETCH);
    end

    always_comb begin
        verdict           = '0;
        verdict.rd_update = is_rd || is_fe;
        unique case (mode)
            MODE_IDLE: begin
                verdict.use_sub  = 1'b0;
                verdict.wr_pass  = is_wr && wr_en;
                verdict.set_viol = is_wr && !wr_en;
            end
            MODE_SINGLE: begin
                verdict.use_sub  = 1'b1;
                verdict.set_viol = is_wr;
            end
            MODE_BLOCK: begin
                verdict.use_sub = 1'b1;
                if (!wait_bit) begin
                    verdict.set_viol = is_rd || is_wr || is_fe;
                    verdict.set_lock = is_rd || is_wr || is_fe;
                end else begin
                    verdict.wr_pass  = is_wr && wr_en;
                    verdict.set_viol = (is_wr && !wr_en) || is_fe;
                    verdict.set_lock = is_fe;
                end
            end
            default: begin
                verdict.rd_update = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fbg_sticky_flags.sv
module fbg_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                        flags[g] <= 1'b0;
            else if (set_vec[g])            flags[g] <= 1'b1;
            else if (clr_wr && !clr_data[g]) flags[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_busy_guard.sv
module flash_busy_guard
    import fbg_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter logic [DATA_W-1:0] SUB_OPCODE = 16'h3FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              busy_in,
    input  logic              blk_mode_in,
    input  logic              wait_in,
    input  logic              wr_en_in,
    input  logic              flag_wr,
    input  logic [1:0]        flag_wdata,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              array_we,
    output logic [DATA_W-1:0] array_wdata,
    output logic              viol_flag,
    output logic              lock_flag
);

    mode_e              mode_q;
    verdict_t           verdict;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;

    fbg_mode_fsm u_mode (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy_in),
        .blk    (blk_mode_in),
        .mode_q (mode_q)
    );

    fbg_policy u_policy (
        .mode      (mode_q),
        .acc_valid (acc_valid),
        .acc_kind  (acc_kind),
        .wait_bit  (wait_in),
        .wr_en     (wr_en_in),
        .verdict   (verdict)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_VIOL] = verdict.set_viol;
        set_vec[FLAG_LOCK] = verdict.set_lock;
    end

    fbg_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_wr   (flag_wr),
        .clr_data (flag_wdata),
        .flags    (flags)
    );

    assign viol_flag = flags[FLAG_VIOL];
    assign lock_flag = flags[FLAG_LOCK];

    // Output register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata   <= '0;
            array_we    <= 1'b0;
            array_wdata <= '0;
        end else begin
            array_we <= verdict.wr_pass;
            if (verdict.wr_pass)
                array_wdata <= cpu_wdata;
            if (verdict.rd_update)
                cpu_rdata <= verdict.use_sub ? SUB_OPCODE : array_rdata;
        end
    end

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
    import fbg_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter logic [DATA_W-1:0] SUB_OPCODE = 16'h3FFF
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic              wait_in,
    input logic              wr_en_in,
    input logic              flag_wr,
    input logic [1:0]        flag_wdata,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              array_we,
    input logic              viol_flag,
    input logic              lock_flag,
    input mode_e             mode
);

    logic rd_or_fe;
    logic wr_acc;
    logic any_acc;
    assign rd_or_fe = acc_valid && (acc_kind == 2'b00 || acc_kind == 2'b10);
    assign wr_acc   = acc_valid && (acc_kind == 2'b01);
    assign any_acc  = acc_valid && (acc_kind != 2'b11);

    assert_idle_read_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IDLE && rd_or_fe) |=> cpu_rdata == $past(array_rdata));

    assert_we_source_R3: assert property (@(posedge clk) disable iff (rst)
        array_we |-> $past(wr_acc && wr_en_in));

    assert_wren_block_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && !wr_en_in) |=> (!array_we && viol_flag));

    assert_single_sub_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE && rd_or_fe) |=> cpu_rdata == SUB_OPCODE);

    assert_single_write_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE && wr_acc) |=> (!array_we && viol_flag));

    assert_block_nowait_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && !wait_in && any_acc) |=> (viol_flag && lock_flag && !array_we));

    assert_lock_origin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |-> $past(mode == MODE_BLOCK && any_acc));

    assert_block_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && wait_in && acc_valid && acc_kind == 2'b10) |=> (viol_flag && lock_flag));

    assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !(flag_wr && !flag_wdata[0])) |=> viol_flag);

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (lock_flag && !(flag_wr && !flag_wdata[1])) |=> lock_flag);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_or_fe |=> $stable(cpu_rdata));

endmodule

bind flash_busy_guard fbg_checker #(.DATA_W(DATA_W), .SUB_OPCODE(SUB_OPCODE)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_kind    (acc_kind),
    .wait_in     (wait_in),
    .wr_en_in    (wr_en_in),
    .flag_wr     (flag_wr),
    .flag_wdata  (flag_wdata),
    .array_rdata (array_rdata),
    .cpu_rdata   (cpu_rdata),
    .array_we    (array_we),
    .viol_flag   (viol_flag),
    .lock_flag   (lock_flag),
    .mode        (mode_q)
);

// File: tb/flash_busy_guard_tb_top.sv
`timescale 1ns/100ps
module flash_busy_guard_tb_top;

    localparam int DW = 16;
    localparam logic [DW-1:0] SUB = 16'h3FFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_kind = 2'b11;
    logic [DW-1:0] cpu_wdata = '0;
    logic          busy_in = 1'b0;
    logic          blk_mode_in = 1'b0;
    logic          wait_in = 1'b0;
    logic          wr_en_in = 1'b0;
    logic          flag_wr = 1'b0;
    logic [1:0]    flag_wdata = 2'b11;
    logic [DW-1:0] array_rdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          array_we;
    logic [DW-1:0] array_wdata;
    logic          viol_flag;
    logic          lock_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_busy_guard #(.DATA_W(DW), .SUB_OPCODE(SUB)) dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .cpu_wdata(cpu_wdata), .busy_in(busy_in), .blk_mode_in(blk_mode_in),
        .wait_in(wait_in), .wr_en_in(wr_en_in), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .array_rdata(array_rdata), .cpu_rdata(cpu_rdata),
        .array_we(array_we), .array_wdata(array_wdata), .viol_flag(viol_flag),
        .lock_flag(lock_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Clear both flags with a one-cycle software write of zeros.
    task automatic clear_flags();
        flag_wr = 1'b1; flag_wdata = 2'b00;
        step();
        flag_wr = 1'b0; flag_wdata = 2'b11;
    endtask

    // Mode code: 0 idle, 1 single, 2 block.
    task automatic set_mode(input int m);
        busy_in     = (m != 0);
        blk_mode_in = (m == 2);
        step();
    endtask

    logic [DW-1:0] exp_rdata = '0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1", "viol", viol_flag, 0);
        check("R1", "lock", lock_flag, 0);
        check("R1", "rdata", cpu_rdata, 0);
        check("R1", "we", array_we, 0);
        check("R1", "wdata", array_wdata, 0);

        // Full sweep of mode x wait x wr_en x kind.
        for (int m = 0; m < 3; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int k = 0; k < 3; k++) begin
                        logic ev, el, ewe, rdu, sub;
                        logic [DW-1:0] pat;
                        string tag;
                        pat = DW'(16'h1000 + m * 16'h100 + w * 16'h40 + e * 16'h10 + k);
                        ev = 0; el = 0; ewe = 0;
                        rdu = (k != 1);
                        sub = (m != 0);
                        if (m == 0) begin
                            ewe = (k == 1) && e;
                            ev  = (k == 1) && !e;
                            tag = (k == 1) ? (e ? "R3" : "R4") : "R3";
                        end else if (m == 1) begin
                            ev  = (k == 1);
                            tag = (k == 1) ? "R6" : "R5";
                        end else if (w == 0) begin
                            ev = 1; el = 1;
                            tag = "R7";
                        end else begin
                            ewe = (k == 1) && e;
                            ev  = ((k == 1) && !e) || (k == 2);
                            el  = (k == 2);
                            tag = (k == 2) ? "R9" : ((k == 1 && !e) ? "R4" : "R8");
                        end
                        set_mode(m);
                        clear_flags();
                        acc_valid = 1'b1; acc_kind = 2'(k);
                        wait_in = w[0]; wr_en_in = e[0];
                        array_rdata = pat; cpu_wdata = pat ^ 16'hA5A5;
                        step();
                        acc_valid = 1'b0; acc_kind = 2'b11;
                        if (rdu) exp_rdata = sub ? SUB : pat;
                        check(tag, "rdata", cpu_rdata, exp_rdata);
                        check(tag, "we", array_we, ewe);
                        check(tag, "viol", viol_flag, ev);
                        check(tag, "lock", lock_flag, el);
                        if (ewe) check(tag, "wdata", array_wdata, pat ^ 16'hA5A5);
                        step();
                        check("R11", "we pulse", array_we, 0);
                        check("R11", "rdata hold", cpu_rdata, exp_rdata);
                    end
                end
            end
        end

        // R2: busy rising in the access cycle is not yet seen.
        set_mode(0);
        clear_flags();
        busy_in = 1'b1; blk_mode_in = 1'b0;
        acc_valid = 1'b1; acc_kind = 2'b00; array_rdata = 16'h1234;
        step();
        check("R2", "rdata same cycle", cpu_rdata, 16'h1234);
        array_rdata = 16'h5678;
        step();
        check("R2", "rdata next cycle", cpu_rdata, SUB);
        // Busy falls: next access after one edge sees real data again.
        busy_in = 1'b0;
        step();
        check("R2", "rdata at busy fall", cpu_rdata, SUB);
        array_rdata = 16'h9ABC;
        step();
        check("R3", "real data after busy", cpu_rdata, 16'h9ABC);
        acc_valid = 1'b0; acc_kind = 2'b11;

        // R10: stickiness and per-bit clear.
        acc_valid = 1'b1; acc_kind = 2'b01; wr_en_in = 1'b0;
        step();
        acc_valid = 1'b0; acc_kind = 2'b11;
        repeat (3) step();
        check("R10", "viol sticky", viol_flag, 1);
        flag_wr = 1'b1; flag_wdata = 2'b11;
        step();
        flag_wr = 1'b0;
        check("R10", "write 1 keeps viol", viol_flag, 1);
        set_mode(2);
        wait_in = 1'b0;
        acc_valid = 1'b1; acc_kind = 2'b00;
        step();
        acc_valid = 1'b0; acc_kind = 2'b11;
        check("R10", "lock set", lock_flag, 1);
        flag_wr = 1'b1; flag_wdata = 2'b10;
        step();
        flag_wr = 1'b0; flag_wdata = 2'b11;
        check("R10", "viol cleared alone", viol_flag, 0);
        check("R10", "lock kept", lock_flag, 1);
        set_mode(0);
        flag_wr = 1'b1; flag_wdata = 2'b00;
        acc_valid = 1'b1; acc_kind = 2'b01; wr_en_in = 1'b0;
        step();
        flag_wr = 1'b0; flag_wdata = 2'b11;
        acc_valid = 1'b0; acc_kind = 2'b11;
        check("R10", "set wins over clear", viol_flag, 1);
        check("R10", "lock cleared", lock_flag, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule